// File: doc/BRIEF.md
# Flash Program/Erase Control with Interrupt Gating

This block holds the control bits that drive program and erase operations of an on-chip flash array. Software sets a software-enable bit, a program-setup or erase-setup bit, and then the program or erase bit, through a small register port. The block enforces the conditions under which the program and erase bits may stay set. It clears them on reset, on a watchdog reset, in standby, when the external write-enable pin is low, and when the software-enable bit is 0.

The block also gates the CPU side. It produces a registered NMI mask that is held while a program or erase is active, while the error-protection flag is raised, and during the boot phase. The boot phase runs from reset until the boot code signals its branch into on-chip RAM, and it counts only when the part starts in boot mode. Flash reads made while a program or erase bit is set are flagged invalid. A watchdog-required output tells the system to keep the watchdog running while any setup or active bit is 1.

Top module: `flash_pe_ctrl`

## Requirements
- R1: An active-low `rst_n` (asynchronous) or a high `wdt_rst_i` at a clock edge clears every control bit and re-arms the boot phase. `nmi_mask_o` is 1 while `rst_n` is low.
- R2: Register 0 (`reg_addr_i`=0) holds the control bits: bit0 software enable, bit1 program setup, bit2 program, bit3 erase setup, bit4 erase. All other bits read 0. Register 1 is read-only: bit0 NMI mask, bit1 effective boot lock, bit2 error-protection flag, bit3 pin level. Reads are combinational from the current state.
- R3: While `wen_pin_i` is low at a clock edge, all five control bits are cleared and a write to register 0 has no effect.
- R4: While `standby_i` is high at a clock edge, the program and erase bits are cleared, and a write cannot set them.
- R5: If the software-enable bit is 0 after an edge, the program and erase bits are 0, even with the pin high.
- R6: A write sets the program bit only if program setup is already 1 and the same write keeps program setup at 1. Otherwise the program bit becomes 0. The same rule holds for the erase bit and erase setup.
- R7: A write that requests both program and erase leaves both bits at 0.
- R8: `nmi_mask_o` is registered. After each edge it equals program OR erase of the new state, OR `err_prot_i` sampled at that edge, OR the effective boot lock.
- R9: The boot phase is set by any reset and cleared by a one-cycle `boot_branch_i` strobe. It masks NMI only while `boot_mode_i` is high.
- R10: `flash_rd_valid_o` equals `flash_rd_i` while the program and erase bits are both 0, and is 0 otherwise.
- R11: `wdt_req_o` is 1 exactly when any of program setup, program, erase setup or erase is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_rst_i | input | 1 | Synchronous reset from the watchdog |
| standby_i | input | 1 | Standby mode active |
| wen_pin_i | input | 1 | Flash write-enable pin level |
| err_prot_i | input | 1 | Error-protection state |
| boot_mode_i | input | 1 | Device started in boot mode |
| boot_branch_i | input | 1 | One-cycle strobe: boot code entered RAM |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data |
| flash_rd_i | input | 1 | CPU flash read in progress |
| flash_rd_valid_o | output | 1 | Flash read data is valid |
| nmi_mask_o | output | 1 | NMI masked |
| wdt_req_o | output | 1 | Watchdog must be running |

## Verification
A wrong control bit is visible on register 0 in the same cycle it is held, and on `wdt_req_o` and `flash_rd_valid_o` right away. A wrong boot-phase or mask value shows on `nmi_mask_o` and register 1 one edge after the input that caused it. The bench compares every output against a behavioural model on every cycle. Directed sequences drive each forced-clear condition while the program or erase bit is set, and drive the setup-ordering corner cases, so a lost clear path shows within one cycle.

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wdt_rst_i,
  input  logic          standby_i,
  input  logic          wen_pin_i,
  input  logic          err_prot_i,
  input  logic          boot_mode_i,
  input  logic          boot_branch_i,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          flash_rd_i,
  output logic          flash_rd_valid_o,
  output logic          nmi_mask_o,
  output logic          wdt_req_o
);

  localparam int B_SWE = 0;
  localparam int B_PSU = 1;
  localparam int B_P   = 2;
  localparam int B_ESU = 3;
  localparam int B_E   = 4;
  localparam int B_NMI = 0;
  localparam int B_BOOT = 1;
  localparam int B_ERR = 2;
  localparam int B_PIN = 3;

  logic swe_q, psu_q, p_q, esu_q, e_q, boot_q, nmi_q;
  logic swe_d, psu_d, p_d, esu_d, e_d, boot_d;

  wire wr_ctl = reg_we_i & ~reg_addr_i;
  wire w_swe = reg_wdata_i[B_SWE];
  wire w_psu = reg_wdata_i[B_PSU];
  wire w_p   = reg_wdata_i[B_P];
  wire w_esu = reg_wdata_i[B_ESU];
  wire w_e   = reg_wdata_i[B_E];
  wire w_both = w_p & w_e;

  always_comb begin
    swe_d = swe_q;
    psu_d = psu_q;
    p_d   = p_q;
    esu_d = esu_q;
    e_d   = e_q;
    if (wr_ctl) begin
      swe_d = w_swe;
      psu_d = w_psu;
      esu_d = w_esu;
      p_d   = w_p & psu_q & w_psu & ~w_both;
      e_d   = w_e & esu_q & w_esu & ~w_both;
    end
    if (!wen_pin_i) begin
      swe_d = 1'b0;
      psu_d = 1'b0;
      esu_d = 1'b0;
      p_d   = 1'b0;
      e_d   = 1'b0;
    end
    if (standby_i || !swe_d) begin
      p_d = 1'b0;
      e_d = 1'b0;
    end
    boot_d = boot_q & ~boot_branch_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {swe_q, psu_q, p_q, esu_q, e_q} <= '0;
      boot_q <= 1'b1;
      nmi_q  <= 1'b1;
    end else if (wdt_rst_i) begin
      {swe_q, psu_q, p_q, esu_q, e_q} <= '0;
      boot_q <= 1'b1;
      nmi_q  <= boot_mode_i | err_prot_i;
    end else begin
      swe_q  <= swe_d;
      psu_q  <= psu_d;
      p_q    <= p_d;
      esu_q  <= esu_d;
      e_q    <= e_d;
      boot_q <= boot_d;
      nmi_q  <= p_d | e_d | err_prot_i | (boot_d & boot_mode_i);
    end
  end

  assign nmi_mask_o       = nmi_q;
  assign flash_rd_valid_o = flash_rd_i & ~(p_q | e_q);
  assign wdt_req_o        = psu_q | p_q | esu_q | e_q;

  always_comb begin
    reg_rdata_o = '0;
    if (!reg_addr_i) begin
      reg_rdata_o[B_SWE] = swe_q;
      reg_rdata_o[B_PSU] = psu_q;
      reg_rdata_o[B_P]   = p_q;
      reg_rdata_o[B_ESU] = esu_q;
      reg_rdata_o[B_E]   = e_q;
    end else begin
      reg_rdata_o[B_NMI]  = nmi_q;
      reg_rdata_o[B_BOOT] = boot_q & boot_mode_i;
      reg_rdata_o[B_ERR]  = err_prot_i;
      reg_rdata_o[B_PIN]  = wen_pin_i;
    end
  end

  AST_WDT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_i |=> !(swe_q || psu_q || p_q || esu_q || e_q)); // R1
  AST_PIN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_pin_i |=> !(swe_q || psu_q || p_q || esu_q || e_q)); // R3
  AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> !(p_q || e_q)); // R4
  AST_SWE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !swe_q |-> !(p_q || e_q)); // R5
  AST_P_NEEDS_PSU: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_q) |-> $past(psu_q) && psu_q); // R6
  AST_E_NEEDS_ESU: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_q) |-> $past(esu_q) && esu_q); // R6
  AST_PE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_q && e_q)); // R7
  AST_NMI_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (p_q || e_q) |-> nmi_mask_o); // R8
  AST_NMI_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_prot_i |=> nmi_mask_o); // R8
  AST_BOOT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_branch_i && !wdt_rst_i) |=> !boot_q); // R9
  AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (p_q || e_q) |-> !flash_rd_valid_o); // R10

endmodule

// File: tb/tb_flash_pe_ctrl.sv
module tb_flash_pe_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_rst = 0, stby = 0, pin = 0, err = 0, bmode = 0, bbr = 0;
  logic we = 0, addr = 0, frd = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdv, nmi, wdtq;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  flash_pe_ctrl #(.DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .wdt_rst_i(wdt_rst), .standby_i(stby),
    .wen_pin_i(pin), .err_prot_i(err), .boot_mode_i(bmode), .boot_branch_i(bbr),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .flash_rd_i(frd), .flash_rd_valid_o(rdv), .nmi_mask_o(nmi), .wdt_req_o(wdtq));

  // behavioural reference state
  bit m_swe, m_psu, m_p, m_esu, m_e, m_boot, m_nmi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || wdt_rst) begin
      m_swe = 0; m_psu = 0; m_p = 0; m_esu = 0; m_e = 0; m_boot = 1;
      m_nmi = !rst_n ? 1'b1 : (bmode | err);
    end else begin
      bit s, ps, p, es, e;
      s = m_swe; ps = m_psu; p = m_p; es = m_esu; e = m_e;
      if (we && !addr) begin
        s = wdata[0]; ps = wdata[1]; es = wdata[3];
        p = wdata[2] && m_psu && wdata[1] && !(wdata[2] && wdata[4]);
        e = wdata[4] && m_esu && wdata[3] && !(wdata[2] && wdata[4]);
      end
      if (!pin) begin s = 0; ps = 0; es = 0; p = 0; e = 0; end
      if (stby || !s) begin p = 0; e = 0; end
      m_swe = s; m_psu = ps; m_p = p; m_esu = es; m_e = e;
      if (bbr) m_boot = 0;
      m_nmi = p | e | err | (m_boot & bmode);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle model comparison, away from both edges
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      logic [7:0] exp_rd;
      if (!addr) exp_rd = {3'b0, m_e, m_esu, m_p, m_psu, m_swe};
      else exp_rd = {4'b0, pin, err, m_boot & bmode, m_nmi};
      check("R2 model rdata", rdata, exp_rd);
      check("R8 model nmi", nmi, m_nmi);
      check("R10 model rdvalid", rdv, frd & !(m_p | m_e));
      check("R11 model wdtreq", wdtq, m_psu | m_p | m_esu | m_e);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1; addr = 0; wdata = d;
    @(negedge clk); we = 0; #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    pin = 1;
    step(2);
    check("R1 reset nmi", nmi, 1);
    check("R1 reset ctrl", rdata, 0);
    rst_n = 1;
    step(1);
    check("R9 no boot mode unmasked", nmi, 0);

    wr(8'h03); wr(8'h07);
    check("R6 program set", rdata, 8'h07);
    check("R11 wdt req", wdtq, 1);
    check("R8 nmi during program", nmi, 1);
    frd = 1; #1;
    check("R10 read invalid", rdv, 0);

    @(negedge clk); pin = 0; step(1);
    check("R3 pin low clears", rdata, 0);
    wr(8'h03);
    check("R3 write ignored", rdata, 0);
    check("R10 read valid", rdv, 1);
    frd = 0;
    @(negedge clk); pin = 1; step(1);

    wr(8'h01); wr(8'h05);
    check("R6 program without setup", rdata, 8'h01);
    wr(8'h0B); wr(8'h1F);
    check("R7 both requested", rdata, 8'h0B);
    wr(8'h0B); wr(8'h19);
    check("R6 erase set", rdata, 8'h19);
    wr(8'h0B); wr(8'h0F);
    @(negedge clk); stby = 1; step(1);
    check("R4 standby clears", rdata, 8'h0B);
    wr(8'h0F);
    check("R4 standby blocks", rdata, 8'h0B);
    @(negedge clk); stby = 0; step(1);

    wr(8'h07);
    check("R6 program again", rdata, 8'h07);
    wr(8'h06);
    check("R5 swe low clears program", rdata, 8'h02);

    @(negedge clk); err = 1; step(1);
    check("R8 err masks nmi", nmi, 1);
    @(negedge clk); err = 0; step(1);
    check("R8 err released", nmi, 0);

    @(negedge clk); bmode = 1; wdt_rst = 1; step(1);
    wdt_rst = 0;
    check("R1 wdt reset clears", rdata, 0);
    check("R9 boot lock masks", nmi, 1);
    addr = 1; #1;
    check("R2 status boot lock", rdata, 8'h0B);
    addr = 0;
    step(3);
    check("R9 boot lock holds", nmi, 1);
    @(negedge clk); bbr = 1; @(negedge clk); bbr = 0; #1;
    check("R9 branch unmasks", nmi, 0);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      we    = ($urandom % 3) == 0;
      addr  = ($urandom % 4) == 0;
      wdata = 8'($urandom);
      pin   = ($urandom % 16) != 0;
      stby  = ($urandom % 20) == 0;
      err   = ($urandom % 25) == 0;
      bbr   = ($urandom % 40) == 0;
      wdt_rst = ($urandom % 200) == 0;
      if (($urandom % 300) == 0) bmode = ~bmode;
      frd   = $urandom % 2;
    end
    @(negedge clk); we = 0;
    step(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule